// File: doc/BRIEF.md
# Control-Register Bus Target Register File

This block is the target end of a four-phase control-register bus. A master reaches a small array of 16-bit registers through four strobes, one 16-bit input word, one 16-bit output word and one acknowledge line. The address and the write data each arrive in a handshake of their own. They are latched into an internal address register and a holding register. A third handshake, the write strobe, copies the holding register into the array entry named by the latched address. A read strobe loads that entry onto the output word.

Each handshake starts when exactly one strobe rises. After a fixed, parameterised number of cycles the target raises acknowledge. Acknowledge stays high until the master lowers the strobe, and it falls on the next clock edge. Every array entry is also driven out in parallel, so neighbouring logic can use the stored settings directly. The array depth and the acknowledge latency are parameters. Strobes are taken as synchronous to the block clock.

Top module: `crt_target`

## Requirements
- R1: While `rst` is high and after it is released, `ack_o` is 0, `dout_o` is 0, every array entry reads as 0, and the address and holding registers are 0.
- R2: A strobe is taken at the first clock edge that samples it high when it was low at the edge before. An address strobe taken this way latches `din_i` as the register address and is acknowledged.
- R3: A data strobe latches `din_i` into the holding register and is acknowledged. It leaves every array entry unchanged.
- R4: A write strobe copies the holding register into the entry at the latched address and is acknowledged. The value of `din_i` is ignored during a write. Entry i appears on `regs_o[16*i+15 : 16*i]`.
- R5: A read strobe loads the entry at the latched address into `dout_o` at the edge that takes the strobe. That value is valid while `ack_o` is high and holds until the next read.
- R6: `ack_o` first reads high after the edge that lies LATENCY edges beyond the taking edge. It stays high while the active strobe stays high, and it falls at the first edge that samples that strobe low.
- R7: If the latched address is DEPTH or above, a write changes nothing and a read returns 0. Both are still acknowledged.
- R8: If more than one strobe is high at an edge while the target is idle, no strobe is taken. No acknowledge follows, and neither the address, the holding register nor the array changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_stb_i | input | 1 | Address-capture strobe |
| data_stb_i | input | 1 | Data-capture strobe |
| rd_stb_i | input | 1 | Read strobe |
| wr_stb_i | input | 1 | Write-commit strobe |
| din_i | input | 16 | Address or data word from the master |
| dout_o | output | 16 | Read data word |
| ack_o | output | 1 | Handshake acknowledge |
| regs_o | output | 16*DEPTH | All array entries, entry i in bits 16*i+15 down to 16*i |

## Verification
The latched address, holding register, array entry and read word all change at the very edge that takes a strobe. Acknowledge appears only LATENCY edges later, and it falls one edge after the strobe drops. The bench raises each strobe just after a falling clock edge and counts the falling-edge samples until acknowledge reads high, expecting exactly LATENCY+1. It reads `dout_o` in that same sample. After lowering the strobe it checks that acknowledge reads low at the very next falling edge. State that a strobe must leave untouched is checked through `regs_o` or a later read, never through internals.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int unsigned CR_W = 16;

    typedef logic [CR_W-1:0] word_t;

    // Strobe vector bit order: {write, read, data, address}
    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_DATA  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_WAIT,
        HS_ACK
    } hs_e;

    typedef struct packed {
        logic valid;
        op_e  op;
    } req_t;

    function automatic op_e op_from_onehot(input logic [3:0] s);
        op_e r;
        r = OP_ADDR;
        if (s[1]) r = OP_DATA;
        if (s[2]) r = OP_READ;
        if (s[3]) r = OP_WRITE;
        return r;
    endfunction

endpackage

// File: rtl/crt_strobe_det.sv
module crt_strobe_det
    import crt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] stb_i,
    input  logic       idle_i,
    output req_t       req_o
);
    logic [3:0] prev_q;
    logic [3:0] rise;
    logic       single;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stb_i;
    end

    assign rise   = stb_i & ~prev_q;
    assign single = ($countones(stb_i) == 1);

    always_comb begin
        req_o.valid = idle_i && single && (|rise);
        req_o.op    = op_from_onehot(stb_i);
    end
endmodule

// File: rtl/crt_handshake.sv
module crt_handshake
    import crt_pkg::*;
#(
    parameter int unsigned LATENCY = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  req_t       req_i,
    input  logic [3:0] stb_i,
    output logic       ack_o,
    output logic       idle_o
);
    localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam int unsigned LOAD  = (LATENCY > 0) ? LATENCY - 1 : 0;

    hs_e              st_q;
    op_e              act_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HS_IDLE;
            act_q <= OP_ADDR;
            cnt_q <= '0;
            ack_o <= 1'b0;
        end else begin
            case (st_q)
                HS_IDLE: begin
                    if (req_i.valid) begin
                        act_q <= req_i.op;
                        if (LATENCY == 0) begin
                            st_q  <= HS_ACK;
                            ack_o <= 1'b1;
                        end else begin
                            st_q  <= HS_WAIT;
                            cnt_q <= CNT_W'(LOAD);
                        end
                    end
                end
                HS_WAIT: begin
                    if (cnt_q == '0) begin
                        st_q  <= HS_ACK;
                        ack_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                HS_ACK: begin
                    if (!stb_i[act_q]) begin
                        st_q  <= HS_IDLE;
                        ack_o <= 1'b0;
                    end
                end
                default: begin
                    st_q  <= HS_IDLE;
                    ack_o <= 1'b0;
                end
            endcase
        end
    end

    assign idle_o = (st_q == HS_IDLE);
endmodule

// File: rtl/crt_regfile.sv
module crt_regfile
    import crt_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  req_t                 req_i,
    input  word_t                din_i,
    output word_t                dout_o,
    output logic [DEPTH*CR_W-1:0] regs_o
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    word_t             addr_q;
    word_t             hold_q;
    word_t             arr_q [DEPTH];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = (32'(addr_q) < DEPTH);
    assign idx      = addr_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            hold_q <= '0;
            dout_o <= '0;
            for (int i = 0; i < int'(DEPTH); i++) arr_q[i] <= '0;
        end else if (req_i.valid) begin
            case (req_i.op)
                OP_ADDR:  addr_q <= din_i;
                OP_DATA:  hold_q <= din_i;
                OP_READ:  dout_o <= in_range ? arr_q[idx] : '0;
                OP_WRITE: if (in_range) arr_q[idx] <= hold_q;
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_out
        assign regs_o[g*CR_W +: CR_W] = arr_q[g];
    end
endmodule

// File: rtl/crt_target.sv
module crt_target
    import crt_pkg::*;
#(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned LATENCY = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  addr_stb_i,
    input  logic                  data_stb_i,
    input  logic                  rd_stb_i,
    input  logic                  wr_stb_i,
    input  logic [15:0]           din_i,
    output logic [15:0]           dout_o,
    output logic                  ack_o,
    output logic [DEPTH*16-1:0]   regs_o
);
    logic [3:0] stb;
    logic       idle;
    req_t       req;

    assign stb = {wr_stb_i, rd_stb_i, data_stb_i, addr_stb_i};

    crt_strobe_det u_det (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (stb),
        .idle_i (idle),
        .req_o  (req)
    );

    crt_handshake #(.LATENCY(LATENCY)) u_hs (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .stb_i  (stb),
        .ack_o  (ack_o),
        .idle_o (idle)
    );

    crt_regfile #(.DEPTH(DEPTH)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .din_i  (din_i),
        .dout_o (dout_o),
        .regs_o (regs_o)
    );
endmodule

// File: rtl/crt_target_chk.sv
module crt_target_chk #(
    parameter int unsigned DEPTH = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                addr_stb_i,
    input logic                data_stb_i,
    input logic                rd_stb_i,
    input logic                wr_stb_i,
    input logic [15:0]         dout_o,
    input logic                ack_o,
    input logic [DEPTH*16-1:0] regs_o
);
    logic [3:0] stb;
    assign stb = {wr_stb_i, rd_stb_i, data_stb_i, addr_stb_i};

    // R6
    ack_falls_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && stb == 4'b0) |=> !ack_o);

    // R6
    ack_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && $stable(stb) && stb != 4'b0) |=> ack_o);

    // R3
    regs_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_o) |-> $past(wr_stb_i));

    // R5
    dout_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_o) |-> $past(rd_stb_i));
endmodule

bind crt_target crt_target_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_stb_i (addr_stb_i),
    .data_stb_i (data_stb_i),
    .rd_stb_i   (rd_stb_i),
    .wr_stb_i   (wr_stb_i),
    .dout_o     (dout_o),
    .ack_o      (ack_o),
    .regs_o     (regs_o)
);

// File: tb/crt_target_tb.sv
module crt_target_tb;
    localparam int unsigned DEPTH   = 8;
    localparam int unsigned LATENCY = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        stb = 4'b0;
    logic [15:0]       din = '0;
    logic [15:0]       dout;
    logic              ack;
    logic [DEPTH*16-1:0] regs;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    crt_target #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .addr_stb_i (stb[0]),
        .data_stb_i (stb[1]),
        .rd_stb_i   (stb[2]),
        .wr_stb_i   (stb[3]),
        .din_i      (din),
        .dout_o     (dout),
        .ack_o      (ack),
        .regs_o     (regs)
    );

    // op codes: 0 address, 1 data, 2 read, 3 write
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] din;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{2'd0, 16'h0003, 16'h0000},
        '{2'd1, 16'hA5A5, 16'h0000},
        '{2'd3, 16'hFFFF, 16'h0000},
        '{2'd2, 16'h0000, 16'hA5A5},
        '{2'd0, 16'h0007, 16'h0000},
        '{2'd1, 16'h1234, 16'h0000},
        '{2'd3, 16'h0F0F, 16'h0000},
        '{2'd2, 16'h0000, 16'h1234},
        '{2'd0, 16'h0003, 16'h0000},
        '{2'd2, 16'h0000, 16'hA5A5},
        '{2'd0, 16'h0000, 16'h0000},
        '{2'd2, 16'h0000, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full handshake; returns read word and number of samples until ack.
    task automatic run_op(input int op, input logic [15:0] d, input int hold_extra,
                          output logic [15:0] rv, output int lat);
        bit got;
        got = 0;
        lat = 0;
        rv  = '0;
        @(negedge clk);
        din = d;
        stb = 4'b0001 << op;
        while (!got && lat < int'(LATENCY) + 8) begin
            @(negedge clk);
            lat++;
            if (ack) got = 1;
        end
        rv = dout;
        for (int i = 0; i < hold_extra; i++) begin
            @(negedge clk);
            chk(ack == 1'b1, "R6 ack held", 32'(ack), 32'd1);
        end
        stb = 4'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R6 ack drop", 32'(ack), 32'd0);
    endtask

    initial begin
        logic [15:0]       rv;
        int                lat;
        logic [DEPTH*16-1:0] snap;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ack == 1'b0, "R1 ack", 32'(ack), 0);
        chk(dout == 16'h0, "R1 dout", 32'(dout), 0);
        chk(regs == '0, "R1 regs", 32'(regs[31:0]), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(regs == '0 && ack == 1'b0, "R1 after release", 32'(regs[31:0]), 0);

        // Vector walk: R2 R3 R4 R5 R6
        for (int v = 0; v < 12; v++) begin
            run_op(int'(VEC[v].op), VEC[v].din, 0, rv, lat);
            chk(lat == int'(LATENCY) + 1, "R6 latency", 32'(lat), LATENCY + 1);
            if (VEC[v].op == 2'd2)
                chk(rv == VEC[v].exp, "R5 read word", 32'(rv), 32'(VEC[v].exp));
        end

        // R4 parallel output
        chk(regs[3*16 +: 16] == 16'hA5A5, "R4 entry3", 32'(regs[3*16 +: 16]), 32'hA5A5);
        chk(regs[7*16 +: 16] == 16'h1234, "R4 entry7", 32'(regs[7*16 +: 16]), 32'h1234);
        chk(regs[0 +: 16] == 16'h0, "R4 entry0", 32'(regs[0 +: 16]), 0);

        // R3 data capture alone leaves the array unchanged
        run_op(0, 16'h0005, 0, rv, lat);
        run_op(1, 16'hBEEF, 0, rv, lat);
        chk(lat == int'(LATENCY) + 1, "R3 ack", 32'(lat), LATENCY + 1);
        chk(regs[5*16 +: 16] == 16'h0, "R3 no array change", 32'(regs[5*16 +: 16]), 0);
        run_op(3, 16'h0000, 0, rv, lat);
        chk(regs[5*16 +: 16] == 16'hBEEF, "R4 commit hold", 32'(regs[5*16 +: 16]), 32'hBEEF);

        // R5 read word held across other handshakes
        run_op(2, 16'h0000, 0, rv, lat);
        run_op(0, 16'h0001, 0, rv, lat);
        chk(dout == 16'hBEEF, "R5 dout held", 32'(dout), 32'hBEEF);

        // R7 out-of-range address
        snap = regs;
        run_op(0, 16'd20, 0, rv, lat);
        run_op(1, 16'h7777, 0, rv, lat);
        run_op(3, 16'h0000, 0, rv, lat);
        chk(lat == int'(LATENCY) + 1, "R7 write acked", 32'(lat), LATENCY + 1);
        chk(regs == snap, "R7 write ignored", 32'(regs[31:0]), 32'(snap[31:0]));
        run_op(2, 16'h0000, 0, rv, lat);
        chk(lat == int'(LATENCY) + 1, "R7 read acked", 32'(lat), LATENCY + 1);
        chk(rv == 16'h0, "R7 read zero", 32'(rv), 0);

        // R8 conflicting strobes
        run_op(0, 16'h0003, 0, rv, lat);
        snap = regs;
        @(negedge clk);
        din = 16'h0007;
        stb = 4'b1001;
        for (int i = 0; i < int'(LATENCY) + 4; i++) begin
            @(negedge clk);
            chk(ack == 1'b0, "R8 no ack", 32'(ack), 0);
        end
        stb = 4'b0;
        @(negedge clk);
        chk(regs == snap, "R8 array unchanged", 32'(regs[31:0]), 32'(snap[31:0]));
        run_op(2, 16'h0000, 0, rv, lat);
        chk(rv == 16'hA5A5, "R8 address unchanged", 32'(rv), 32'hA5A5);

        // R6 long strobe keeps ack high
        run_op(2, 16'h0000, 5, rv, lat);
        chk(lat == int'(LATENCY) + 1, "R6 long latency", 32'(lat), LATENCY + 1);

        // R1 reset mid-run clears the array
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(regs == '0 && dout == 16'h0, "R1 re-reset", 32'(regs[31:0]), 0);
        rst = 1'b0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule